// File: doc/BRIEF.md
# Dual-Bank Crosspoint Routing Controller

This block works out which pass devices of a small crosspoint fabric should be closed. Two source banks, A and B, share four output ports numbered 0 to 3. Each bank carries an enable bit and a two-bit port select. An enabled bank drives exactly one port. A disabled bank drives none. When both banks name the same port, bank A keeps it and bank B is left floating (high impedance).

The six control bits come from one of two places, chosen by a mode input. In pin mode they are read from six shared control pins. In register mode they are taken from the upper six bits of an 8-bit control register held elsewhere. The low four shared pins change direction with the mode: they are inputs in pin mode and outputs in register mode. The two remaining pins are released (no drive) in register mode, and their levels are then ignored. The block drives an output enable for every shared pin.

The routing outputs are purely combinational. A change of mode or of any selected control bit reaches the connect vectors in the same cycle, with no register in the path.

Top module: `route_xbar_ctl`

## Requirements
- R1: When a bank's enable bit is 0, all four bits of that bank's connect vector are 0 and its high-impedance flag is 1.
- R2: When a bank's enable bit is 1 and the bank is not overruled, its connect vector is one-hot, with bit k set for select value k. Its high-impedance flag is 0.
- R3: When both banks are enabled with equal selects, bank A connects to that port, bank B's connect vector is 0 and bank B's high-impedance flag is 1. No port is ever driven by both banks.
- R4: With mode = 0, the controls come from ctrl_pin_i: bits [1:0] are the A select, bit 2 the A enable, bits [4:3] the B select, and bit 5 the B enable.
- R5: With mode = 1, the controls come from ctrl_reg_i: bits [3:2] are the A select, bit 4 the A enable, bits [6:5] the B select, and bit 7 the B enable.
- R6: Bits [1:0] of ctrl_reg_i never affect any output. In mode 1 no bit of ctrl_pin_i affects any output. In mode 0 no bit of ctrl_reg_i affects any output.
- R7: pin_oe_o is 6'b000000 in mode 0. In mode 1 it is 6'b001111: the four low shared pins are driven and pins 4 and 5 are released.
- R8: While a bank is disabled, its select bits have no effect on either bank's outputs.
- R9: Outputs follow a change of mode or of a control bit with no clock latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mode_i | input | 1 | Control source: 0 = shared pins, 1 = register field |
| ctrl_pin_i | input | 6 | Levels seen on the shared control pins |
| ctrl_reg_i | input | 8 | Control register contents (bits [7:2] used) |
| a_conn_o | output | 4 | Bank A port connect vector, bit k closes port k |
| b_conn_o | output | 4 | Bank B port connect vector, bit k closes port k |
| a_hiz_o | output | 1 | Bank A connects to no port |
| b_hiz_o | output | 1 | Bank B connects to no port |
| pin_oe_o | output | 6 | Output enable per shared control pin |

## Verification
All 64 combinations of both enables and both selects are applied in each mode. Meanwhile the unselected source and the two unused register bits carry random values. This separates a wrong field mapping (R4, R5) from leakage of an ignored source (R6). The diagonal combinations, where both selects are equal with both banks enabled, set the precedence rule (R3) apart from plain decoding. The combinations with a disabled bank and a varying select show whether disabled selects stay don't-care (R8). Random patterns with mode toggling between two unequal sources, each sampled right after the change, catch a stale or registered source (R9).

// File: rtl/route_xbar_pkg.sv
package route_xbar_pkg;
  typedef enum logic {
    SRC_PINS = 1'b0,
    SRC_REG  = 1'b1
  } ctrl_src_e;

  localparam int unsigned NUM_BANKS = 2;

  // Closed-port vector for one bank: one-hot on the select when enabled
  function automatic logic [31:0] port_onehot(input logic en, input int unsigned sel);
    logic [31:0] v;
    v = '0;
    if (en) v[sel] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/rt_ctrl_select.sv
module rt_ctrl_select #(
  parameter int unsigned CTRL_W  = 6,
  parameter int unsigned REG_LSB = 2,
  localparam int unsigned REG_W  = CTRL_W + REG_LSB
) (
  input  logic              mode_i,
  input  logic [CTRL_W-1:0] pin_i,
  input  logic [REG_W-1:0]  reg_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  import route_xbar_pkg::*;

  logic unused_reg_low;
  assign unused_reg_low = ^reg_i[REG_LSB-1:0];

  always_comb begin
    unique case (ctrl_src_e'(mode_i))
      SRC_REG:  ctrl_o = reg_i[REG_W-1:REG_LSB];
      default:  ctrl_o = pin_i;
    endcase
  end
endmodule

// File: rtl/rt_bank_decode.sv
module rt_bank_decode #(
  parameter int unsigned NUM_PORTS = 4,
  localparam int unsigned SEL_W    = $clog2(NUM_PORTS)
) (
  input  logic                 en_i,
  input  logic [SEL_W-1:0]     sel_i,
  output logic [NUM_PORTS-1:0] req_o
);
  import route_xbar_pkg::*;

  logic [31:0] full;
  logic unused_hi;

  assign full      = port_onehot(en_i, int'(sel_i));
  assign req_o     = full[NUM_PORTS-1:0];
  assign unused_hi = ^full;
endmodule

// File: rtl/rt_port_arbiter.sv
module rt_port_arbiter #(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic [NUM_PORTS-1:0] a_req_i,
  input  logic [NUM_PORTS-1:0] b_req_i,
  output logic [NUM_PORTS-1:0] a_conn_o,
  output logic [NUM_PORTS-1:0] b_conn_o,
  output logic                 clash_o
);
  // Bank A has fixed precedence on a shared port
  assign a_conn_o = a_req_i;
  assign b_conn_o = b_req_i & ~a_req_i;
  assign clash_o  = |(a_req_i & b_req_i);
endmodule

// File: rtl/rt_pin_dir.sv
module rt_pin_dir #(
  parameter int unsigned PIN_W    = 6,
  parameter int unsigned OUT_PINS = 4
) (
  input  logic             mode_i,
  output logic [PIN_W-1:0] oe_o
);
  import route_xbar_pkg::*;

  for (genvar p = 0; p < PIN_W; p++) begin : g_pin
    if (p < OUT_PINS) begin : g_shared
      assign oe_o[p] = (ctrl_src_e'(mode_i) == SRC_REG);
    end else begin : g_released
      assign oe_o[p] = 1'b0;
    end
  end
endmodule

// File: rtl/route_xbar_ctl.sv
module route_xbar_ctl #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned REG_LSB   = 2,
  parameter int unsigned OUT_PINS  = 4,
  localparam int unsigned SEL_W    = $clog2(NUM_PORTS),
  localparam int unsigned BANK_W   = SEL_W + 1,
  localparam int unsigned CTRL_W   = route_xbar_pkg::NUM_BANKS * BANK_W,
  localparam int unsigned REG_W    = CTRL_W + REG_LSB
) (
  input  logic                 mode_i,
  input  logic [CTRL_W-1:0]    ctrl_pin_i,
  input  logic [REG_W-1:0]     ctrl_reg_i,
  output logic [NUM_PORTS-1:0] a_conn_o,
  output logic [NUM_PORTS-1:0] b_conn_o,
  output logic                 a_hiz_o,
  output logic                 b_hiz_o,
  output logic [CTRL_W-1:0]    pin_oe_o
);
  import route_xbar_pkg::*;

  // Named internal events, brought out for the checker
  logic [CTRL_W-1:0]    ctrl_sel;
  logic [NUM_PORTS-1:0] bank_req [NUM_BANKS];
  logic                 b_overruled;

  rt_ctrl_select #(.CTRL_W(CTRL_W), .REG_LSB(REG_LSB)) u_src (
    .mode_i (mode_i),
    .pin_i  (ctrl_pin_i),
    .reg_i  (ctrl_reg_i),
    .ctrl_o (ctrl_sel)
  );

  // Bank 0 is A, bank 1 is B; each slice is {enable, select}
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    rt_bank_decode #(.NUM_PORTS(NUM_PORTS)) u_dec (
      .en_i  (ctrl_sel[b*BANK_W + SEL_W]),
      .sel_i (ctrl_sel[b*BANK_W +: SEL_W]),
      .req_o (bank_req[b])
    );
  end

  rt_port_arbiter #(.NUM_PORTS(NUM_PORTS)) u_arb (
    .a_req_i  (bank_req[0]),
    .b_req_i  (bank_req[1]),
    .a_conn_o (a_conn_o),
    .b_conn_o (b_conn_o),
    .clash_o  (b_overruled)
  );

  assign a_hiz_o = ~|a_conn_o;
  assign b_hiz_o = ~|b_conn_o;

  rt_pin_dir #(.PIN_W(CTRL_W), .OUT_PINS(OUT_PINS)) u_dir (
    .mode_i (mode_i),
    .oe_o   (pin_oe_o)
  );
endmodule

// File: rtl/route_xbar_ctl_chk.sv
module route_xbar_ctl_chk #(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned CTRL_W    = 6,
  parameter int unsigned REG_W     = 8,
  parameter int unsigned OUT_PINS  = 4
) (
  input logic                 mode_i,
  input logic [CTRL_W-1:0]    ctrl_pin_i,
  input logic [REG_W-1:0]     ctrl_reg_i,
  input logic [NUM_PORTS-1:0] a_conn_o,
  input logic [NUM_PORTS-1:0] b_conn_o,
  input logic                 a_hiz_o,
  input logic                 b_hiz_o,
  input logic [CTRL_W-1:0]    pin_oe_o,
  input logic                 b_overruled
);
  logic a_en_src, b_en_src;
  assign a_en_src = mode_i ? ctrl_reg_i[4] : ctrl_pin_i[2];
  assign b_en_src = mode_i ? ctrl_reg_i[7] : ctrl_pin_i[5];

  always_comb begin
    // R1
    a_off_chk: assert (a_en_src || (a_conn_o == '0 && a_hiz_o))
      else $error("bank A drives while disabled");
    // R1
    b_off_chk: assert (b_en_src || (b_conn_o == '0 && b_hiz_o))
      else $error("bank B drives while disabled");
    // R2
    a_onehot_chk: assert ($onehot0(a_conn_o) && ($countones(a_conn_o) == (a_hiz_o ? 0 : 1)))
      else $error("bank A connect vector not one-hot");
    // R2
    b_onehot_chk: assert ($onehot0(b_conn_o) && ($countones(b_conn_o) == (b_hiz_o ? 0 : 1)))
      else $error("bank B connect vector not one-hot");
    // R3
    no_shared_port_chk: assert ((a_conn_o & b_conn_o) == '0)
      else $error("a port is driven by both banks");
    // R3
    overrule_chk: assert (!b_overruled || (b_hiz_o && !a_hiz_o))
      else $error("overruled bank B still connected");
    // R7
    pin_dir_chk: assert (pin_oe_o == (mode_i ? CTRL_W'((1 << OUT_PINS) - 1) : '0))
      else $error("shared pin direction wrong");
  end
endmodule

bind route_xbar_ctl route_xbar_ctl_chk #(
  .NUM_PORTS(NUM_PORTS), .CTRL_W(CTRL_W), .REG_W(REG_W), .OUT_PINS(OUT_PINS)
) u_chk (
  .mode_i      (mode_i),
  .ctrl_pin_i  (ctrl_pin_i),
  .ctrl_reg_i  (ctrl_reg_i),
  .a_conn_o    (a_conn_o),
  .b_conn_o    (b_conn_o),
  .a_hiz_o     (a_hiz_o),
  .b_hiz_o     (b_hiz_o),
  .pin_oe_o    (pin_oe_o),
  .b_overruled (b_overruled)
);

// File: tb/sim_route_xbar_ctl.sv
module sim_route_xbar_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int SEED       = 1234;

  logic       clk = 1'b0;
  logic       mode;
  logic [5:0] pins;
  logic [7:0] regv;
  logic [3:0] a_conn, b_conn;
  logic       a_hiz, b_hiz;
  logic [5:0] pin_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  route_xbar_ctl u0 (
    .mode_i(mode), .ctrl_pin_i(pins), .ctrl_reg_i(regv),
    .a_conn_o(a_conn), .b_conn_o(b_conn),
    .a_hiz_o(a_hiz), .b_hiz_o(b_hiz), .pin_oe_o(pin_oe)
  );

  // Expected {a_conn, b_conn, a_hiz, b_hiz} from the six controls, packed as
  // {b_en, b_sel[1:0], a_en, a_sel[1:0]}
  function automatic logic [9:0] expect_route(input logic [5:0] c);
    logic [3:0] ea, eb;
    ea = 4'b0; eb = 4'b0;
    for (int k = 0; k < 4; k++) begin
      if (c[2] && c[1:0] == k[1:0]) ea[k] = 1'b1;
      if (c[5] && c[4:3] == k[1:0] && !(c[2] && c[1:0] == k[1:0])) eb[k] = 1'b1;
    end
    return {ea, eb, (ea == 4'b0), (eb == 4'b0)};
  endfunction

  function automatic logic [5:0] expect_oe(input logic m);
    return m ? 6'b001111 : 6'b000000;
  endfunction

  task automatic apply(input logic m, input logic [5:0] p, input logic [7:0] r);
    @(posedge clk);
    mode = m; pins = p; regv = r;
    #1;
  endtask

  task automatic check_route(input string req, input logic [5:0] c);
    logic [9:0] got, exp;
    got = {a_conn, b_conn, a_hiz, b_hiz};
    exp = expect_route(c);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: mode=%0b ctrl=%b got=%b expected=%b", req, mode, c, got, exp);
    end
  endtask

  task automatic check_oe(input string req);
    n_tests++;
    if (pin_oe !== expect_oe(mode)) begin
      n_fail++;
      $display("FAIL %s: mode=%0b pin_oe got=%b expected=%b", req, mode, pin_oe, expect_oe(mode));
    end
  endtask

  initial begin
    void'($urandom(SEED));
    mode = 1'b0; pins = 6'b0; regv = 8'b0;

    // Idle state: nothing routed, pins are inputs
    apply(1'b0, 6'b0, 8'b0);
    check_route("R1 idle", 6'b0);
    check_oe("R7 idle");

    // Exhaustive in pin mode, register side random (R4, R6)
    for (int c = 0; c < 64; c++) begin
      apply(1'b0, 6'(c), 8'($urandom));
      check_route("R4 R1 R2 R3 R6", 6'(c));
      check_oe("R7 mode0");
    end

    // Exhaustive in register mode, pins and reg[1:0] random (R5, R6)
    for (int c = 0; c < 64; c++) begin
      apply(1'b1, 6'($urandom), {6'(c), 2'($urandom)});
      check_route("R5 R1 R2 R3 R6", 6'(c));
      check_oe("R7 mode1");
    end

    // R3 diagonal: both enabled, same select
    for (int s = 0; s < 4; s++) begin
      apply(1'b0, {1'b1, 2'(s), 1'b1, 2'(s)}, 8'h00);
      check_route("R3 clash", {1'b1, 2'(s), 1'b1, 2'(s)});
    end

    // R8: disabled bank's select swept; other bank fixed
    for (int s = 0; s < 4; s++) begin
      apply(1'b1, 6'h00, {1'b1, 2'd2, 1'b0, 2'(s), 2'b11});
      check_route("R8 A disabled", {1'b1, 2'd2, 1'b0, 2'(s)});
      apply(1'b1, 6'h3f, {1'b0, 2'(s), 1'b1, 2'd1, 2'b00});
      check_route("R8 B disabled", {1'b0, 2'(s), 1'b1, 2'd1});
    end

    // R6: only reg[1:0] changes; outputs must not move
    apply(1'b1, 6'h15, 8'b1011_0100);
    check_route("R6 low bits 00", 6'b101101);
    apply(1'b1, 6'h15, 8'b1011_0111);
    check_route("R6 low bits 11", 6'b101101);

    // R9: mode toggled between unequal sources, random, sampled 1 time unit later
    for (int i = 0; i < 300; i++) begin
      logic [5:0] p;
      logic [7:0] r;
      logic       m;
      p = 6'($urandom);
      r = 8'($urandom);
      m = 1'($urandom);
      apply(m, p, r);
      check_route("R9 random", m ? r[7:2] : p);
      apply(!m, p, r);
      check_route("R9 mode flip", !m ? r[7:2] : p);
      check_oe("R7 flip");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run hung, got=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule